// File: doc/BRIEF.md
# Transmit Watermark Request and Control-Data Status Unit

This block holds the status and request logic of a serial port. On the transmit side it compares the free-entry count of a 16-entry transmit FIFO against a programmable watermark. It raises a transfer request, for a DMA engine or for software, while enough space is free. Each single DMA access knocks the request down for one cycle. The request then comes back without help if the space is still there.

On the receive side the block keeps one control-data register with a ready flag. A write loads the register and sets the flag. A write that arrives while the flag is already set replaces the data. A read of the register clears the flag. Both flags drive one registered interrupt line, each through its own enable. The FIFO storage and the serial shifter sit outside this block.

Top module: `wmreq_unit`

## Requirements
- R1: The watermark code `wm_code` selects a threshold of 2^min(code,4) free entries: codes 0..4 give 1, 2, 4, 8 and 16, and codes 5..7 give 16. In the cycle after an edge where `tx_en`=1, `tx_free` >= threshold and `dma_ack`=0, the transmit request `stat[2]` is 1.
- R2: The transmit request is live state, not sticky. In the cycle after an edge where `tx_free` is below the threshold, `stat[2]` is 0.
- R3: A DMA access (`dma_ack`=1) clears the request in the next cycle, even when the watermark condition holds in that same cycle. If the condition still holds and no access occurs, the request is set again one cycle later.
- R4: In the cycle after an edge where `tx_en`=0, `stat[2]` is 0, whatever the free count is.
- R5: `dma_req` always equals `stat[2]`.
- R6: A write (`ctl_wr`=1 with `rx_en`=1) loads `ctl_wdata` into the register, which is visible on `ctl_rdata` one cycle later, and sets the ready flag `stat[0]`. A write while the flag is already set replaces the data, and the flag stays 1.
- R7: A read strobe (`ctl_rd`=1 with `rx_en`=1) clears `stat[0]` in the next cycle. When a write and a read come in the same cycle, the write wins: the flag stays 1 and the new data is kept.
- R8: While `rx_en`=0, `stat[0]` reads 0, and writes and reads have no effect on the register or the flag. When receive is enabled again, the previous data and flag return.
- R9: `stat[1]` is a reserved bit and always reads 0.
- R10: `irq` is registered: it equals (`stat[2]` & `ie_tx`) | (`stat[0]` & `ie_rx`) as sampled at the previous clock edge.
- R11: A synchronous reset (`rst`=1) clears both flags, the control-data register and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_free | input | 5 | Free entries in the transmit FIFO (0..16) |
| wm_code | input | 3 | Watermark code |
| dma_ack | input | 1 | One DMA access on the transmit side this cycle |
| ie_tx | input | 1 | Interrupt enable for the transmit request |
| ie_rx | input | 1 | Interrupt enable for control-data ready |
| ctl_wr | input | 1 | Control-data write strobe |
| ctl_wdata | input | 16 | Control-data write value |
| ctl_rd | input | 1 | Control-data read strobe |
| stat | output | 3 | Status: [2] transmit request, [1] reserved 0, [0] control-data ready |
| dma_req | output | 1 | DMA transfer request |
| ctl_rdata | output | 16 | Control-data register contents |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted transmit request flop shows on both `stat[2]` and `dma_req` in the very next cycle. The same error reaches `irq` one cycle after that, since the bench predicts all three from the free count, the code and the DMA strobe. A wrong ready flag or a wrong stored word shows on `stat[0]` or `ctl_rdata` in the cycle right after the write or read that exposed it. Every cycle is compared, so no error stays hidden for more than two clocks.

// File: rtl/wmreq_pkg.sv
package wmreq_pkg;
    // Depth of the transmit FIFO whose free count is watched.
    localparam int FIFO_DEPTH = 16;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int MAX_SHIFT  = $clog2(FIFO_DEPTH);
    localparam int WM_W       = 3;
    localparam int DATA_W     = 16;
    localparam int STAT_W     = 3;

    typedef struct packed {
        logic tx_req;   // bit 2
        logic rsvd;     // bit 1, always zero
        logic ctl_rdy;  // bit 0
    } stat_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } ctl_word_t;

    // Threshold in free entries: 2^code, saturating at the FIFO depth.
    function automatic logic [CNT_W-1:0] wm_thresh(input logic [WM_W-1:0] code);
        int unsigned sh;
        sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
        return {{(CNT_W-1){1'b0}}, 1'b1} << sh;
    endfunction
endpackage

// File: rtl/wmreq_tx_req.sv
module wmreq_tx_req
    import wmreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic [CNT_W-1:0] tx_free,
    input  logic [WM_W-1:0]  wm_code,
    input  logic             dma_ack,
    output logic             tx_req
);
    logic [CNT_W-1:0] thr;
    logic             room_ok;
    logic             req_q;

    always_comb begin
        thr     = wm_thresh(wm_code);
        room_ok = (tx_free >= thr);
    end

    // A DMA access takes priority for one cycle; the flag re-arms afterwards.
    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else
            req_q <= tx_en & room_ok & ~dma_ack;
    end

    assign tx_req = req_q;
endmodule

// File: rtl/wmreq_ctl_reg.sv
module wmreq_ctl_reg
    import wmreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic              rdy
);
    ctl_word_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (rx_en) begin
            if (wr) begin
                nxt.data  = wdata;
                nxt.valid = 1'b1;
            end else if (rd) begin
                nxt.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else
            cur_q <= nxt;
    end

    assign rdata = cur_q.data;
    assign rdy   = cur_q.valid & rx_en;
endmodule

// File: rtl/wmreq_irq.sv
module wmreq_irq
    import wmreq_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] flags,
    input  logic [N_SRC-1:0] enables,
    output logic             irq
);
    logic [N_SRC-1:0] masked;
    logic             irq_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_mask
        assign masked[i] = flags[i] & enables[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |masked;
    end

    assign irq = irq_q;
endmodule

// File: rtl/wmreq_unit.sv
module wmreq_unit
    import wmreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic [CNT_W-1:0]  tx_free,
    input  logic [WM_W-1:0]   wm_code,
    input  logic              dma_ack,
    input  logic              ie_tx,
    input  logic              ie_rx,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              ctl_rd,
    output logic [STAT_W-1:0] stat,
    output logic              dma_req,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic              irq
);
    stat_t st;
    logic  tx_req;
    logic  rdy;

    wmreq_tx_req u_tx (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_free(tx_free),
        .wm_code(wm_code), .dma_ack(dma_ack), .tx_req(tx_req)
    );

    wmreq_ctl_reg u_ctl (
        .clk(clk), .rst(rst), .rx_en(rx_en), .wr(ctl_wr), .wdata(ctl_wdata),
        .rd(ctl_rd), .rdata(ctl_rdata), .rdy(rdy)
    );

    always_comb begin
        st         = '0;
        st.tx_req  = tx_req;
        st.rsvd    = 1'b0;
        st.ctl_rdy = rdy;
    end

    wmreq_irq #(.N_SRC(2)) u_irq (
        .clk(clk), .rst(rst),
        .flags({st.tx_req, st.ctl_rdy}),
        .enables({ie_tx, ie_rx}),
        .irq(irq)
    );

    assign stat    = st;
    assign dma_req = tx_req;
endmodule

// File: rtl/wmreq_unit_chk.sv
module wmreq_unit_chk
    import wmreq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tx_en,
    input logic              rx_en,
    input logic [CNT_W-1:0]  tx_free,
    input logic [WM_W-1:0]   wm_code,
    input logic              dma_ack,
    input logic              ie_tx,
    input logic              ie_rx,
    input logic              ctl_wr,
    input logic [DATA_W-1:0] ctl_wdata,
    input logic              ctl_rd,
    input logic [STAT_W-1:0] stat,
    input logic              dma_req,
    input logic [DATA_W-1:0] ctl_rdata,
    input logic              irq
);
    AST_TX_SET: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !dma_ack && tx_free >= wm_thresh(wm_code)) |=> stat[2]); // R1
    AST_TX_LOW_ROOM: assert property (@(posedge clk) disable iff (rst)
        (tx_free < wm_thresh(wm_code)) |=> !stat[2]); // R2
    AST_TX_DMA_CLEAR: assert property (@(posedge clk) disable iff (rst)
        dma_ack |=> !dma_req); // R3
    AST_TX_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !stat[2]); // R4
    AST_DMA_MATCH: assert property (@(posedge clk) disable iff (rst)
        dma_req == stat[2]); // R5
    AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (rx_en && ctl_wr) |=> (ctl_rdata == $past(ctl_wdata))); // R6
    AST_CTL_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rx_en && ctl_rd && !ctl_wr) |=> !stat[0]); // R7
    AST_CTL_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> $stable(ctl_rdata)); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !stat[1]); // R9
    AST_IRQ_OR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past((stat[2] & ie_tx) | (stat[0] & ie_rx)))); // R10
endmodule

bind wmreq_unit wmreq_unit_chk u_chk (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .tx_free(tx_free),
    .wm_code(wm_code), .dma_ack(dma_ack), .ie_tx(ie_tx), .ie_rx(ie_rx),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd), .stat(stat),
    .dma_req(dma_req), .ctl_rdata(ctl_rdata), .irq(irq)
);

// File: tb/wmreq_unit_test.sv
`timescale 1ns/1ps
module wmreq_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 0, rx_en = 0, dma_ack = 0, ie_tx = 0, ie_rx = 0;
    logic        ctl_wr = 0, ctl_rd = 0;
    logic [4:0]  tx_free = '0;
    logic [2:0]  wm_code = '0;
    logic [15:0] ctl_wdata = '0;
    logic [2:0]  stat;
    logic        dma_req, irq;
    logic [15:0] ctl_rdata;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic        m_tx = 0, m_rdy = 0, m_irq = 0;
    logic [15:0] m_data = '0;

    always #2 clk = ~clk;

    wmreq_unit uut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .tx_free(tx_free),
        .wm_code(wm_code), .dma_ack(dma_ack), .ie_tx(ie_tx), .ie_rx(ie_rx),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd), .stat(stat),
        .dma_req(dma_req), .ctl_rdata(ctl_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int thresh(input int code);
        return 1 << ((code > 4) ? 4 : code);
    endfunction

    // Apply one cycle of stimulus, update the model, check every output.
    task automatic step(input string tag, input logic ten, input logic ren, input int free,
                        input int code, input logic dma, input logic wr, input logic [15:0] wd,
                        input logic rd, input logic iet, input logic ier);
        logic n_tx, n_irq;
        tx_en = ten; rx_en = ren; tx_free = 5'(free); wm_code = 3'(code);
        dma_ack = dma; ctl_wr = wr; ctl_wdata = wd; ctl_rd = rd; ie_tx = iet; ie_rx = ier;
        n_irq = (m_tx & iet) | (m_rdy & ren & ier);
        n_tx  = ten && (free >= thresh(code)) && !dma;
        if (ren && wr) begin
            m_data = wd; m_rdy = 1'b1;
        end else if (ren && rd) begin
            m_rdy = 1'b0;
        end
        m_tx = n_tx; m_irq = n_irq;
        @(posedge clk); #1;
        chk(tag, "stat[2]", 16'(stat[2]), 16'(m_tx));
        chk("R5", "dma_req", 16'(dma_req), 16'(stat[2]));
        chk("R9", "stat[1]", 16'(stat[1]), 16'd0);
        chk(tag, "stat[0]", 16'(stat[0]), 16'(m_rdy & ren));
        chk(tag, "ctl_rdata", ctl_rdata, m_data);
        chk("R10", "irq", 16'(irq), 16'(m_irq));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        m_tx = 0; m_rdy = 0; m_irq = 0; m_data = '0;
        chk("R11", "stat", 16'(stat), 16'd0);
        chk("R11", "ctl_rdata", ctl_rdata, 16'd0);
        chk("R11", "irq", 16'(irq), 16'd0);
        rst = 1'b0;
    endtask

    initial begin
        #1;
        @(posedge clk); #1;
        do_reset();

        // R1 R2 R4: full sweep of code x free x enable x dma
        for (int code = 0; code < 8; code++)
            for (int free = 0; free <= 16; free++)
                for (int en = 0; en < 2; en++)
                    for (int d = 0; d < 2; d++)
                        step((en == 0) ? "R4" : (d ? "R3" : ((free >= thresh(code)) ? "R1" : "R2")),
                             1'(en), 1'b1, free, code, 1'(d), 1'b0, 16'h0, 1'b0, 1'b1, 1'b0);

        // R3: repeated single DMA accesses with room held at maximum
        for (int k = 0; k < 6; k++) begin
            step("R3", 1'b1, 1'b1, 16, 2, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, 1'b1);
            step("R3", 1'b1, 1'b1, 16, 2, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b1);
            step("R3", 1'b1, 1'b1, 16, 2, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b1);
        end

        // R6 R7: write, overwrite, read, write+read
        step("R6", 1'b0, 1'b1, 0, 0, 1'b0, 1'b1, 16'hA5A5, 1'b0, 1'b0, 1'b1);
        step("R6", 1'b0, 1'b1, 0, 0, 1'b0, 1'b1, 16'h3C3C, 1'b0, 1'b0, 1'b1);
        step("R6", 1'b0, 1'b1, 0, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
        step("R7", 1'b0, 1'b1, 0, 0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1);
        step("R7", 1'b0, 1'b1, 0, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
        step("R7", 1'b0, 1'b1, 0, 0, 1'b0, 1'b1, 16'h1234, 1'b1, 1'b0, 1'b1);
        step("R7", 1'b0, 1'b1, 0, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);

        // R8: receive disabled hides flag and ignores write/read
        step("R8", 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
        step("R8", 1'b0, 1'b0, 0, 0, 1'b0, 1'b1, 16'hDEAD, 1'b0, 1'b0, 1'b1);
        step("R8", 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1);
        step("R8", 1'b0, 1'b1, 0, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);

        // R10: every enable combination against both flag states
        for (int p = 0; p < 16; p++)
            step("R10", p[0], 1'b1, p[1] ? 16 : 0, 4, 1'b0, p[2], 16'(p * 16'h0101),
                 ~p[2], p[3], p[0] ^ p[3]);

        // R11: reset mid-run with both flags set
        step("R6", 1'b1, 1'b1, 16, 0, 1'b0, 1'b1, 16'hBEEF, 1'b0, 1'b1, 1'b1);
        step("R1", 1'b1, 1'b1, 16, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b1);
        do_reset();
        step("R11", 1'b0, 1'b1, 0, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule